// File: doc/BRIEF.md
# Clearable 1K x 4 Static Memory

This block is a clocked storage array of 1024 words, 4 bits each, with a 10-bit address. Write data comes in on its own input, and read data leaves on its own output, so the two never share a bus. Four active-low controls are sampled on the rising clock edge: select, write, output enable and clear. Decoding follows a fixed priority. Deselect comes first, then clear, then write, then read. A select with neither write nor read leaves the output off.

A clear request starts a sweep. The sweep writes zero to one word per cycle, walking from address 0 to 1023, and raises `busy` for its full length. While `busy` is high, read and write requests are dropped. A read returns the addressed word on the cycle after the edge that sampled it. In that same cycle the registered `out_drv` flag is high. In every other cycle the data output floats.

The read side is a simple valid stream with no back-pressure. `out_drv` acts as the valid flag and is high for exactly one cycle per accepted read. The consumer must take the word in that cycle, because no ready input exists and the word is not held. Nothing on the write side ever stalls the caller except `busy`, and a request made while `busy` is high is lost, not queued.

Top module: `zclr_sram`

## Requirements
- R1: With `sel_n` high at a clock edge, the block writes nothing, starts no clear and does not drive the output in the next cycle (`out_drv` low).
- R2: With `sel_n` low and `clr_n` low at an edge while `busy` is low, a clear sweep starts and `busy` is high in the next cycle. This holds whatever `wr_n` and `oe_n` are, so clear wins over write.
- R3: A sweep keeps `busy` high for exactly 1024 consecutive cycles, then `busy` returns low.
- R4: After a sweep completes, a read of any address returns 0.
- R5: With `sel_n` low, `clr_n` high, `wr_n` low and `busy` low at an edge, `din` is stored at `addr`. `out_drv` is low in the next cycle.
- R6: With `sel_n` low, `clr_n` high, `wr_n` high, `oe_n` low and `busy` low at an edge, `out_drv` is high in the next cycle and `dout` carries the word stored at `addr`. When `out_drv` is low, `dout` is released to high impedance.
- R7: With `sel_n` low, `clr_n` high, `wr_n` high and `oe_n` high, the output stays off in the next cycle and no word changes.
- R8: While `busy` is high, read, write and further clear requests have no effect. `out_drv` stays low, and words written during the sweep still read 0 afterwards.
- R9: After `rst_n` is released, `busy` and `out_drv` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write request |
| oe_n | input | 1 | Active-low output enable |
| clr_n | input | 1 | Active-low request to clear the whole array |
| addr | input | 10 | Word address for read and write |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, high impedance unless `out_drv` is high |
| out_drv | output | 1 | Read data valid and driven this cycle |
| busy | output | 1 | Clear sweep in progress |

## Verification
The assertions take for granted that the controls are settled, known values at every clock edge once reset is released. They also assume that a read looks only at addresses holding defined data, which means a clear has completed since power-up. The stimulus meets both conditions. It changes every input at the falling edge and never leaves an input unknown. It runs a clear before the first read, and its behavioural model treats every sweep as zeroing the whole array.

// File: rtl/zclr_pkg.sv
package zclr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CLEAR,
    OP_WRITE,
    OP_READ,
    OP_HOLD
  } op_e;
endpackage

// File: rtl/zclr_decode.sv
module zclr_decode
  import zclr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic wr_n,
  input  logic oe_n,
  input  logic clr_n,
  input  logic busy,
  output logic start_clr,
  output logic do_wr,
  output logic do_rd
);
  op_e op;

  // Priority: deselect, clear, write, read, output disabled.
  always_comb begin
    if (sel_n)       op = OP_IDLE;
    else if (!clr_n) op = OP_CLEAR;
    else if (!wr_n)  op = OP_WRITE;
    else if (!oe_n)  op = OP_READ;
    else             op = OP_HOLD;
  end

  assign start_clr = (op == OP_CLEAR) && !busy;
  assign do_wr     = (op == OP_WRITE) && !busy;
  assign do_rd     = (op == OP_READ)  && !busy;

  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_clr, do_wr, do_rd}));

  // R2: a clear request suppresses a simultaneous write
  assert_clear_beats_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !clr_n) |-> !do_wr);
endmodule

// File: rtl/zclr_sweep.sv
module zclr_sweep #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end

  // Independent cycle counter for the sweep length check.
  logic [AW:0] chk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chk_cnt <= '0;
    else if (!busy) chk_cnt <= '0;
    else            chk_cnt <= chk_cnt + 1'b1;
  end

  assert_busy_on_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_sweep_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chk_cnt == (AW+1)'(DEPTH)));

  assert_sweep_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ptr == '0));
endmodule

// File: rtl/zclr_array.sv
module zclr_array #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [AW-1:0]    clr_addr,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (clr_en)  mem[clr_addr] <= '0;
    else if (we) mem[waddr]    <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= re;
      if (re) rdata <= mem[raddr];
    end
  end

  // R8: user ports never act during a sweep
  assert_no_user_in_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !(we || re));
endmodule

// File: rtl/zclr_sram.sv
module zclr_sram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             oe_n,
  input  logic             clr_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             out_drv,
  output logic             busy
);
  logic             start_clr, do_wr, do_rd;
  logic [AW-1:0]    ptr;
  logic [WIDTH-1:0] rd_q;
  logic             rd_drv;

  zclr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .clr_n(clr_n), .busy(busy), .start_clr(start_clr), .do_wr(do_wr),
    .do_rd(do_rd)
  );

  zclr_sweep #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start_clr), .busy(busy), .ptr(ptr)
  );

  zclr_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .clr_en(busy), .clr_addr(ptr),
    .we(do_wr), .waddr(addr), .wdata(din),
    .re(do_rd), .raddr(addr), .rdata(rd_q), .rvalid(rd_drv)
  );

  assign out_drv = rd_drv;
  assign dout    = rd_drv ? rd_q : {WIDTH{1'bz}};

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !out_drv);

  assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && clr_n && !wr_n) |=> !out_drv);

  assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && clr_n && wr_n && !oe_n && !busy) |=> out_drv);

  assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && clr_n && wr_n && oe_n) |=> !out_drv);

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !out_drv);
endmodule

// File: tb/tb_zclr_sram.sv
`timescale 1ns/1ps
module tb_zclr_sram;
  localparam int DEPTH = 1024;
  localparam int WIDTH = 4;
  localparam int AW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WIDTH-1:0] din = '0;
  wire  [WIDTH-1:0] dout;
  wire  out_drv, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [WIDTH-1:0] mem_m [DEPTH];
  bit busy_m = 1'b0;
  int cnt_m  = 0;
  bit drv_m  = 1'b0;
  logic [WIDTH-1:0] q_m = '0;
  string tag_m = "R9";

  always #4 clk = ~clk;

  zclr_sram dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .clr_n(clr_n), .addr(addr), .din(din), .dout(dout), .out_drv(out_drv),
    .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected effect of one clock edge, from the requirements.
  task automatic model_edge(input bit s, input bit w, input bit o, input bit c,
                            input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    drv_m = 1'b0;
    if (busy_m) begin
      cnt_m++;
      if (cnt_m == DEPTH) busy_m = 1'b0;
      tag_m = "R8";
    end else if (s) begin
      tag_m = "R1";
    end else if (!c) begin
      busy_m = 1'b1;
      cnt_m  = 0;
      for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      tag_m = "R2";
    end else if (!w) begin
      mem_m[a] = d;
      tag_m = "R5";
    end else if (!o) begin
      drv_m = 1'b1;
      q_m   = mem_m[a];
      tag_m = "R6";
    end else begin
      tag_m = "R7";
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, check at the next fall.
  task automatic step(input bit s, input bit w, input bit o, input bit c,
                      input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    sel_n = s; wr_n = w; oe_n = o; clr_n = c; addr = a; din = d;
    @(posedge clk);
    model_edge(s, w, o, c, a, d);
    @(negedge clk);
    check(out_drv == drv_m, tag_m, "out_drv", int'(out_drv), int'(drv_m));
    check(busy == busy_m, "R3", "busy", int'(busy), int'(busy_m));
    if (drv_m)
      check(dout == q_m, "R6", "dout", int'(dout), int'(q_m));
  endtask

  task automatic idle_until_free();
    while (busy_m) step(1'b0, 1'b0, 1'b0, 1'b1, AW'($urandom), WIDTH'($urandom));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9", "busy in reset", int'(busy), 0);
    check(out_drv == 1'b0, "R9", "out_drv in reset", int'(out_drv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R9", "busy after reset", int'(busy), 0);
    check(out_drv == 1'b0, "R9", "out_drv after reset", int'(out_drv), 0);

    // R2: clear together with a write request; R3 sweep length; R8 requests ignored
    begin
      int len;
      step(1'b0, 1'b0, 1'b0, 1'b0, 10'd7, 4'hF);
      check(busy == 1'b1, "R2", "busy after clear", int'(busy), 1);
      len = 0;
      while (busy_m) begin
        step(1'b0, $urandom_range(1), 1'b0, 1'b1, AW'($urandom), WIDTH'($urandom));
        len++;
      end
      check(len == DEPTH, "R3", "sweep cycles", len, DEPTH);
    end

    // R4: every word reads zero after the sweep
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, AW'(a), 4'h0);
      check(out_drv && dout == 4'h0, "R4", "word after clear", int'(dout), 0);
    end

    // R5/R6 at the address edges, back to back
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'd0, 4'h9);
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'd1023, 4'h6);
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd0, 4'h0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd1023, 4'h0);

    // R1: deselected write leaves the word alone
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'd5, 4'hA);
    step(1'b1, 1'b0, 1'b0, 1'b0, 10'd5, 4'h3);
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd5, 4'h0);
    check(dout == 4'hA, "R1", "word after deselected write", int'(dout), 10);

    // R7: output disabled, contents kept
    step(1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 4'h1);
    check(out_drv == 1'b0, "R7", "out_drv with oe_n high", int'(out_drv), 0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd5, 4'h0);
    check(dout == 4'hA, "R7", "word after disabled cycle", int'(dout), 10);

    // R8: writes during a sweep are lost
    step(1'b0, 1'b1, 1'b1, 1'b0, 10'd0, 4'h0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'd1023, 4'hC);
    idle_until_free();
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'd1023, 4'h0);
    check(dout == 4'h0, "R8", "write during sweep", int'(dout), 0);

    // Constrained random mix
    for (int n = 0; n < 6000; n++) begin
      bit s, w, o, c;
      logic [AW-1:0] a;
      s = ($urandom_range(7) == 0);
      w = $urandom_range(1);
      o = ($urandom_range(3) == 0);
      c = ($urandom_range(499) != 0);
      a = $urandom_range(1) ? AW'($urandom_range(15)) : AW'($urandom);
      step(s, w, o, c, a, WIDTH'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule